// File: doc/BRIEF.md
# Rectangle Move and Fill Engine

This block is a two-dimensional drawing engine that works entirely inside a word-addressed video memory. Each memory word is 16 bits wide. The engine handles two kinds of work. It can move a rectangle, combining every source pixel with the pixel already at the destination through an 8-bit raster operation. It can also fill a rectangle with one colour. Pixels are 8 or 16 bits deep.

Software programs a small register file through a single-cycle write port. The registers hold the geometry, the operation and the colour. Setting the start bit launches the job. Software then polls the busy flag until the engine is idle again.

Overlapping moves need the right walk order. For every move, software picks between two orders:
- **Ascending:** rows top to bottom, pixels left to right. Use it when the destination is at or below the source address.
- **Descending:** starts at the last pixel of the last row and walks back to the first. Use it when the destination is above the source address.

Either order means no source pixel is overwritten before it is read.

Top module: `blit_rop_engine`

## Requirements
- R1: After reset `busy` and `mem_req` are 0, and every register reads back 0.
- R2: The registers sit at these offsets and read back what was written while idle:
  - 0 control: bit0 start/busy, bit1 pixel depth (1 = 16 bpp). Bit0 reads the busy state.
  - 1 operation: low byte raster op, high byte opcode.
  - 2/3 source byte address low/high.
  - 4/5 destination byte address low/high.
  - 6 line pitch.
  - 7 width minus one.
  - 8 height minus one.
  - 9 colour.
- R3: Writing 1 to control bit0 while idle makes `busy` read 1 from the next cycle. It stays 1 for exactly 1 cycle per fill pixel, 3 cycles per move pixel, or 1 cycle for an unknown opcode.
- R4: Opcode 0x00 (fill) writes the colour into every pixel of the destination rectangle and changes no other byte. At 8 bpp only colour bits [7:0] are used.
- R5: Opcode 0x01 moves pixels in ascending order: rows top to bottom, pixels left to right. Each pixel is read from memory just before it is used.
- R6: Opcode 0x02 moves pixels in descending order. It starts at source/destination plus height×pitch plus width×bytes-per-pixel, and decrements to the top-left pixel.
- R7: Every result bit is bit {s,d} of the raster-op byte, where s and d are the source and destination bits. So 0xCC copies, 0xAA keeps the destination, 0x33 inverts the source, 0x66 is XOR, 0x00 clears and 0xFF sets.
- R8: Byte address = {high,low} truncated to the address width. The pitch counts 16-bit words. Width and height are pixel and line counts minus one.
- R9: At 8 bpp an even byte address uses word bits [7:0] and an odd one bits [15:8]. A write enables only that byte lane. At 16 bpp both lanes are written.
- R10: Writing 0 to control bit0 while busy ends the job. `busy` is 0 from the next cycle, and no memory access follows.
- R11: Writes to any register while busy are ignored. The running job and the read-back values are unchanged.
- R12: An opcode other than 0x00, 0x01 or 0x02 finishes after one busy cycle without touching memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read-back of the addressed register |
| busy | output | 1 | Job in progress |
| mem_req | output | 1 | Video memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |

## Verification
The bench builds the engine with a 17-bit byte address and 8-bit width and height fields. With this setting the high address register carries a real bit, so a rectangle placed above the first 64 KB tests the address split. The whole 128 KB memory also fits in the bench, so after every job each byte is compared against a pixel-by-pixel model. Any stray write anywhere is caught this way.

The sweep covers:
- both pixel depths and six raster ops;
- disjoint moves, plus overlapping moves in both walk orders;
- single-pixel rectangles and odd byte lanes;
- abort, writes while busy, and an undefined opcode.

// File: rtl/blit_rop_engine.sv
module blit_rop_engine #(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  localparam int AW = ADDR_W;
  localparam logic [3:0] A_CTRL = 4'd0, A_OPER = 4'd1, A_SRCL = 4'd2, A_SRCH = 4'd3,
                         A_DSTL = 4'd4, A_DSTH = 4'd5, A_PTCH = 4'd6, A_WID  = 4'd7,
                         A_HGT  = 4'd8, A_COL  = 4'd9;
  localparam logic [7:0] OP_FILL = 8'h00, OP_ASC = 8'h01, OP_DSC = 8'h02;

  typedef enum logic [2:0] {S_IDLE, S_NOP, S_RSRC, S_RDST, S_WR} st_t;
  st_t state;

  logic             dep16;
  logic [7:0]       rop, opc;
  logic [15:0]      src_lo, src_hi, dst_lo, dst_hi, pitch, color;
  logic [DIM_W-1:0] wid, hgt, col, row;
  logic [AW-1:0]    cur_s, cur_d, row_s, row_d;
  logic [15:0]      sword;
  logic             dir_dn, fill_m;

  wire idle   = (state == S_IDLE);
  wire ctl_wr = cfg_we && (cfg_addr == A_CTRL);
  wire start  = ctl_wr && cfg_wdata[0] && idle;
  wire abort  = ctl_wr && !cfg_wdata[0] && !idle;
  wire eff_dep = (ctl_wr && idle) ? cfg_wdata[1] : dep16;

  wire [16:0]   pb17    = {pitch, 1'b0};
  wire [AW-1:0] pitch_b = AW'(pb17);
  wire [AW-1:0] step_b  = AW'(dep16 ? 2'd2 : 2'd1);
  wire [31:0]   span_y  = 32'(hgt) * 32'(pb17);
  wire [31:0]   span_x  = 32'(wid) << eff_dep;
  wire [AW-1:0] end_off = AW'(span_y + span_x);
  wire [AW-1:0] src_b   = AW'({src_hi, src_lo});
  wire [AW-1:0] dst_b   = AW'({dst_hi, dst_lo});
  wire [AW-1:0] nrow_s  = dir_dn ? row_s - pitch_b : row_s + pitch_b;
  wire [AW-1:0] nrow_d  = dir_dn ? row_d - pitch_b : row_d + pitch_b;
  wire          last_c  = (col == wid);
  wire          last_r  = (row == hgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dep16 <= 1'b0; rop <= '0; opc <= '0;
      src_lo <= '0; src_hi <= '0; dst_lo <= '0; dst_hi <= '0;
      pitch <= '0; wid <= '0; hgt <= '0; color <= '0;
    end else if (cfg_we && idle) begin
      case (cfg_addr)
        A_CTRL: dep16  <= cfg_wdata[1];
        A_OPER: {opc, rop} <= cfg_wdata;
        A_SRCL: src_lo <= cfg_wdata;
        A_SRCH: src_hi <= cfg_wdata;
        A_DSTL: dst_lo <= cfg_wdata;
        A_DSTH: dst_hi <= cfg_wdata;
        A_PTCH: pitch  <= cfg_wdata;
        A_WID:  wid    <= cfg_wdata[DIM_W-1:0];
        A_HGT:  hgt    <= cfg_wdata[DIM_W-1:0];
        A_COL:  color  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; col <= '0; row <= '0; dir_dn <= 1'b0; fill_m <= 1'b0;
      cur_s <= '0; cur_d <= '0; row_s <= '0; row_d <= '0; sword <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          col    <= '0;
          row    <= '0;
          dir_dn <= (opc == OP_DSC);
          fill_m <= (opc == OP_FILL);
          cur_s  <= (opc == OP_DSC) ? src_b + end_off : src_b;
          row_s  <= (opc == OP_DSC) ? src_b + end_off : src_b;
          cur_d  <= (opc == OP_DSC) ? dst_b + end_off : dst_b;
          row_d  <= (opc == OP_DSC) ? dst_b + end_off : dst_b;
          case (opc)
            OP_FILL:        state <= S_WR;
            OP_ASC, OP_DSC: state <= S_RSRC;
            default:        state <= S_NOP;
          endcase
        end
        S_NOP:  state <= S_IDLE;
        S_RSRC: state <= S_RDST;
        S_RDST: begin
          sword <= mem_rdata;
          state <= S_WR;
        end
        S_WR: begin
          state <= fill_m ? S_WR : S_RSRC;
          if (last_c) begin
            col <= '0;
            if (last_r) state <= S_IDLE;
            else begin
              row   <= row + 1'b1;
              row_s <= nrow_s; cur_s <= nrow_s;
              row_d <= nrow_d; cur_d <= nrow_d;
            end
          end else begin
            col   <= col + 1'b1;
            cur_s <= dir_dn ? cur_s - step_b : cur_s + step_b;
            cur_d <= dir_dn ? cur_d - step_b : cur_d + step_b;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire [7:0]  s_byte = cur_s[0] ? sword[15:8] : sword[7:0];
  wire [7:0]  d_byte = cur_d[0] ? mem_rdata[15:8] : mem_rdata[7:0];
  wire [15:0] s_pix  = dep16 ? sword : {2{s_byte}};
  wire [15:0] d_pix  = dep16 ? mem_rdata : {2{d_byte}};
  logic [15:0] rop_out;

  for (genvar i = 0; i < 16; i++) begin : g_rop
    assign rop_out[i] = rop[{s_pix[i], d_pix[i]}];
  end

  assign busy      = !idle;
  assign mem_req   = (state == S_RSRC) || (state == S_RDST) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_RSRC) ? cur_s[AW-1:1] : cur_d[AW-1:1];
  assign mem_be    = dep16 ? 2'b11 : (cur_d[0] ? 2'b10 : 2'b01);
  assign mem_wdata = fill_m ? (dep16 ? color : {2{color[7:0]}}) : rop_out;

  always_comb begin
    case (cfg_addr)
      A_CTRL:  cfg_rdata = {14'd0, dep16, busy};
      A_OPER:  cfg_rdata = {opc, rop};
      A_SRCL:  cfg_rdata = src_lo;
      A_SRCH:  cfg_rdata = src_hi;
      A_DSTL:  cfg_rdata = dst_lo;
      A_DSTH:  cfg_rdata = dst_hi;
      A_PTCH:  cfg_rdata = pitch;
      A_WID:   cfg_rdata = 16'(wid);
      A_HGT:   cfg_rdata = 16'(hgt);
      A_COL:   cfg_rdata = color;
      default: cfg_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/blit_rop_engine_chk.sv
module blit_rop_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_addr,
  input logic [15:0] cfg_wdata,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic        dep16,
  input logic [15:0] color
);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 4'd0 && cfg_wdata[0] && !busy) |=> busy);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 4'd0 && !cfg_wdata[0] && busy) |=> (!busy && !mem_req));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R9
  lane_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !dep16) |-> ($countones(mem_be) == 1));

  // R9
  wide_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && dep16) |-> (mem_be == 2'b11));

  // R11
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_addr == 4'd9) |=> $stable(color));
endmodule

bind blit_rop_engine blit_rop_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_be(mem_be), .dep16(dep16), .color(color)
);

// File: tb/blit_rop_engine_bench.sv
`timescale 1ns/1ps
module blit_rop_engine_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic busy, mem_req, mem_we;
  logic [AW-2:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] vmem [0:NB/2-1];
  logic [7:0]  ref_b [0:NB-1];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  blit_rop_engine #(.ADDR_W(AW), .DIM_W(DW)) u_blit_rop_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) vmem[mem_addr][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) vmem[mem_addr][15:8] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= vmem[mem_addr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [7:0] mem_byte(input int a);
    logic [15:0] w;
    w = vmem[a >> 1];
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [15:0] rop_of(input logic [7:0] r, input logic [15:0] s, input logic [15:0] d);
    return ({16{r[0]}} & ~s & ~d) | ({16{r[1]}} & ~s & d) |
           ({16{r[2]}} & s & ~d)  | ({16{r[3]}} & s & d);
  endfunction

  task automatic sync_ref();
    for (int i = 0; i < NB; i++) ref_b[i] = mem_byte(i);
  endtask

  task automatic model(input logic [7:0] op, input logic [7:0] r, input int src, input int dst,
                       input int pitch, input int w, input int h, input bit dep, input logic [15:0] colr);
    int bpp;
    bpp = dep ? 2 : 1;
    if (op > 8'h02) return;
    for (int y = 0; y <= h; y++) begin
      for (int x = 0; x <= w; x++) begin
        int yy, xx, sa, da;
        logic [15:0] sp, dp, res;
        yy = (op == 8'h02) ? h - y : y;
        xx = (op == 8'h02) ? w - x : x;
        sa = (src + yy * pitch * 2 + xx * bpp) & (NB - 1);
        da = (dst + yy * pitch * 2 + xx * bpp) & (NB - 1);
        sp = dep ? {ref_b[sa + 1], ref_b[sa]} : {8'h00, ref_b[sa]};
        dp = dep ? {ref_b[da + 1], ref_b[da]} : {8'h00, ref_b[da]};
        res = (op == 8'h00) ? colr : rop_of(r, sp, dp);
        ref_b[da] = res[7:0];
        if (dep) ref_b[da + 1] = res[15:8];
      end
    end
  endtask

  task automatic compare_all(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < NB; i++) begin
      if (mem_byte(i) != ref_b[i]) begin
        if (first < 0) first = i;
        bad++;
      end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(mem_byte(first)), int'(ref_b[first]));
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      cyc++;
      if (cyc > 100000) break;
    end
  endtask

  task automatic setup(input logic [7:0] op, input logic [7:0] r, input int src, input int dst,
                       input int pitch, input int w, input int h, input logic [15:0] colr);
    cfg_wr(4'd1, {op, r});
    cfg_wr(4'd2, 16'(src)); cfg_wr(4'd3, 16'(src >> 16));
    cfg_wr(4'd4, 16'(dst)); cfg_wr(4'd5, 16'(dst >> 16));
    cfg_wr(4'd6, 16'(pitch)); cfg_wr(4'd7, 16'(w)); cfg_wr(4'd8, 16'(h));
    cfg_wr(4'd9, colr);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] r, input int src, input int dst,
                        input int pitch, input int w, input int h, input bit dep,
                        input logic [15:0] colr, input string req);
    int cyc, expc;
    setup(op, r, src, dst, pitch, w, h, colr);
    model(op, r, src, dst, pitch, w, h, dep, colr);
    cfg_wr(4'd0, {14'd0, dep, 1'b1});
    wait_idle(cyc);
    expc = (op == 8'h00) ? (w + 1) * (h + 1) : (op <= 8'h02) ? 3 * (w + 1) * (h + 1) : 1;
    check(cyc == expc, "R3 busy cycles", cyc, expc);
    compare_all(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [7:0] rops [6];
    int cyc;
    rops = '{8'hCC, 8'hFF, 8'h33, 8'h00, 8'hAA, 8'h66};
    for (int i = 0; i < NB / 2; i++) vmem[i] = 16'(i * 40503) ^ 16'(i >> 3);
    sync_ref();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);
    for (int a = 0; a < 10; a++) begin
      cfg_rd(4'(a), rd);
      check(rd == 16'd0, "R1 register reset", rd, 0);
    end

    // R2 readback
    setup(8'h01, 8'hC3, 16'hA5A4, 16'h0001, 16'h1234, 16'h00AB, 16'h0077, 16'hBEEF);
    cfg_wr(4'd0, 16'h0002);
    cfg_rd(4'd0, rd); check(rd == 16'h0002, "R2 control depth readback", rd, 2);
    cfg_rd(4'd1, rd); check(rd == 16'h01C3, "R2 operation readback", rd, 16'h01C3);
    cfg_rd(4'd2, rd); check(rd == 16'hA5A4, "R2 source low readback", rd, 16'hA5A4);
    cfg_rd(4'd7, rd); check(rd == 16'h00AB, "R2 width readback", rd, 16'hAB);
    cfg_rd(4'd9, rd); check(rd == 16'hBEEF, "R2 colour readback", rd, 16'hBEEF);

    // R4 R9 fills at both depths, odd lanes, single pixel
    run_op(8'h00, 8'h00, 0, 16'h0101, 40, 6, 3, 1'b0, 16'h775A, "R4 R9 fill 8bpp odd start");
    run_op(8'h00, 8'h00, 0, 16'h0600, 40, 0, 0, 1'b0, 16'h0011, "R4 R8 fill single pixel");
    run_op(8'h00, 8'h00, 0, 16'h0800, 33, 4, 5, 1'b1, 16'hC0DE, "R4 fill 16bpp");
    // R8 high address register
    run_op(8'h00, 8'h00, 0, 32'h10100, 40, 3, 2, 1'b1, 16'h1357, "R8 fill above 64KB");

    for (int dp = 0; dp < 2; dp++) begin
      for (int k = 0; k < 6; k++) begin
        run_op(8'h01, rops[k], 16'h1000, 16'h2000, 40, 4, 2, dp[0], 16'h0, "R5 R7 disjoint ascending");
        run_op(8'h01, rops[k], 16'h3010, 16'h3000, 40, 5, 3, dp[0], 16'h0, "R5 R7 overlap ascending");
        run_op(8'h02, rops[k], 16'h5000, 16'h5054, 40, 5, 3, dp[0], 16'h0, "R6 R7 overlap descending");
      end
    end
    run_op(8'h01, 8'h33, 16'h7002, 16'h7002, 40, 7, 4, 1'b1, 16'h0, "R7 in-place invert");
    run_op(8'h01, 8'hCC, 16'h7800, 16'h7804, 40, 7, 2, 1'b0, 16'h0, "R5 ascending smear on forward overlap");
    run_op(8'h02, 8'hCC, 16'h9000, 16'h8FFD, 40, 6, 2, 1'b0, 16'h0, "R6 descending on backward overlap");
    run_op(8'h02, 8'hCC, 16'h9400, 32'h19400, 40, 0, 3, 1'b1, 16'h0, "R6 R8 single column high address");

    // R12 unknown opcode
    run_op(8'h07, 8'hFF, 16'h1000, 16'h1000, 40, 3, 3, 1'b0, 16'h0, "R12 unknown opcode no memory change");

    // R11 writes while busy
    setup(8'h00, 8'h00, 0, 16'hA000, 40, 7, 7, 16'h1234);
    model(8'h00, 8'h00, 0, 16'hA000, 40, 7, 7, 1'b1, 16'h1234);
    cfg_wr(4'd0, 16'h0003);
    cfg_wr(4'd9, 16'hBEEF);
    cfg_wr(4'd7, 16'h0001);
    cfg_wr(4'd0, 16'h0001);
    cfg_rd(4'd9, rd); check(rd == 16'h1234, "R11 colour unchanged while busy", rd, 16'h1234);
    cfg_rd(4'd0, rd); check(rd == 16'h0003, "R11 control depth unchanged while busy", rd, 3);
    wait_idle(cyc);
    compare_all("R11 fill uses original parameters");

    // R10 abort
    setup(8'h00, 8'h00, 0, 16'hC000, 40, 31, 31, 16'h005A);
    cfg_wr(4'd0, 16'h0001);
    repeat (5) @(negedge clk);
    cfg_wr(4'd0, 16'h0000);
    @(negedge clk);
    check(!busy, "R10 busy clear after abort", busy, 0);
    for (int i = 0; i < 4; i++) begin
      check(!mem_req, "R10 no access after abort", mem_req, 0);
      @(negedge clk);
    end
    check(mem_byte(16'hC000) == 8'h5A, "R10 first pixel written", mem_byte(16'hC000), 8'h5A);
    check(mem_byte(16'hC000 + 31 * 80 + 31) == ref_b[16'hC000 + 31 * 80 + 31],
          "R10 last pixel untouched", mem_byte(16'hC000 + 31 * 80 + 31),
          ref_b[16'hC000 + 31 * 80 + 31]);
    sync_ref();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule